// File: doc/BRIEF.md
# Message-signaled interrupt file core

This block holds the interrupt state of one interrupt file that belongs to a hart. Every interrupt identity has one pending bit and one enable bit. A set-pending strobe carrying an identity number marks that identity pending. This is the path that incoming message-signaled writes take once a bus front end has decoded them.

A priority search runs every cycle. It picks the lowest-numbered identity that is both pending and enabled, and a programmable threshold can shorten the range it looks at. The winner is shown on a top-interrupt value. An interrupt line goes to the hart when delivery is enabled and a winner exists.

Software reaches the block through a simple register port. A select code and a word index pick one of these:
- the delivery enable;
- the threshold;
- the claim register, which returns the winner and clears its pending bit when written;
- one 32-bit word of pending bits;
- one 32-bit word of enable bits.

Address decoding, privilege checks and the bus protocol live outside this block. Reads are combinational. Writes take effect at the clock edge.

Top module: `msi_intr_file`

## Requirements
- R1: After reset every pending bit, every enable bit, the delivery enable and the threshold are zero, so `top_val` and `irq` are both 0.
- R2: A `set_valid` strobe with `set_id` in the range 1 to NUM_IDS-1 sets that identity's pending bit at the next edge. Identity 0, and any identity at or above NUM_IDS, changes nothing.
- R3: Bit 0 of pending word 0 and bit 0 of enable word 0 always read 0, and writes to them are ignored.
- R4: The winner is the smallest identity whose pending and enable bits are both set. A lower number means a higher priority.
- R5: When the threshold is nonzero and no larger than NUM_IDS, only identities strictly below the threshold can win. Otherwise every identity can win.
- R6: `top_val` carries the winner in bits 26:16 and again in bits 10:0, with all other bits 0. It is 0 when there is no winner. A read of the claim register returns this same value.
- R7: A write to the claim register ignores its data and clears the pending bit of the current winner. When there is no winner, it changes nothing.
- R8: When a set-pending strobe and a claim write arrive in the same cycle for the same identity, the pending bit stays set.
- R9: Only bit 0 of the delivery register can be written. It reads back in bit 0, and all other bits read 0.
- R10: Only bits 10:0 of the threshold register can be written. All other bits read 0.
- R11: `irq` is 1 exactly when delivery is enabled and a winner exists. It follows the state one edge after the access that changed it.
- R12: The select codes are 0 for delivery, 1 for threshold, 2 for claim, 3 for a pending word and 4 for an enable word. Word `reg_idx` holds identities 32*idx to 32*idx+31, with identity 32*idx+k in bit k. A word index at or beyond NUM_IDS/32 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set-pending strobe |
| set_id | input | 11 | Identity to mark pending |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_idx | input | 6 | Word index for the pending and enable words |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| top_val | output | 32 | Winner identity, in two fields |
| irq | output | 1 | External interrupt line to the hart |

## Verification
The inline assertions check these rules on every cycle:
- a reported winner is truly pending and enabled;
- a winner respects an active threshold;
- a claim write clears the winner's pending bit;
- a same-cycle set-pending keeps that bit set;
- the delivery enable never moves without a write to it.

Only the bench scenarios can show the rest:
- that the lowest qualifying identity wins, and not just some qualifying identity;
- that the two-field encoding is correct;
- the read masks on delivery, threshold and identity 0;
- that out-of-range identities and word indexes are ignored.

// File: rtl/msi_intr_file.sv
module msi_intr_file #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [ID_W-1:0]  set_id,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [ID_W-6:0]  reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [31:0]      top_val,
  output logic             irq
);
  localparam int WORDS = NUM_IDS / 32;
  localparam int IDX_W = ID_W - 5;
  localparam int HI_LSB = 16;
  localparam logic [2:0] SEL_DEL = 3'd0;
  localparam logic [2:0] SEL_THR = 3'd1;
  localparam logic [2:0] SEL_CLM = 3'd2;
  localparam logic [2:0] SEL_PND = 3'd3;
  localparam logic [2:0] SEL_ENA = 3'd4;

  logic [NUM_IDS-1:0] pend, en, pend_nx, en_nx;
  logic               del_en;
  logic [ID_W-1:0]    thr, win;
  logic [31:0]        pend_word, en_word;

  wire wr_del = reg_wr && reg_sel == SEL_DEL;
  wire wr_thr = reg_wr && reg_sel == SEL_THR;
  wire wr_clm = reg_wr && reg_sel == SEL_CLM;
  wire wr_pnd = reg_wr && reg_sel == SEL_PND;
  wire wr_ena = reg_wr && reg_sel == SEL_ENA;
  wire set_ok = set_valid && set_id != '0 && int'(set_id) < NUM_IDS;

  always_comb begin
    int lim;
    lim = (thr != '0 && int'(thr) <= NUM_IDS) ? int'(thr) : NUM_IDS;
    win = '0;
    for (int i = NUM_IDS - 1; i >= 1; i--)
      if (pend[i] && en[i] && i < lim) win = ID_W'(i);
  end

  assign top_val = (32'(win) << HI_LSB) | 32'(win);
  assign irq     = del_en && win != '0;

  always_comb begin
    pend_word = '0;
    en_word   = '0;
    for (int w = 0; w < WORDS; w++)
      if (reg_idx == IDX_W'(w)) begin
        pend_word = pend[w*32 +: 32];
        en_word   = en[w*32 +: 32];
      end
  end

  always_comb begin
    case (reg_sel)
      SEL_DEL: reg_rdata = {31'b0, del_en};
      SEL_THR: reg_rdata = 32'(thr);
      SEL_CLM: reg_rdata = top_val;
      SEL_PND: reg_rdata = pend_word;
      SEL_ENA: reg_rdata = en_word;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    pend_nx = pend;
    en_nx   = en;
    for (int w = 0; w < WORDS; w++)
      if (reg_idx == IDX_W'(w)) begin
        if (wr_pnd) pend_nx[w*32 +: 32] = reg_wdata;
        if (wr_ena) en_nx[w*32 +: 32]   = reg_wdata;
      end
    if (wr_clm && win != '0) pend_nx = pend_nx & ~(NUM_IDS'(1) << win);
    if (set_ok)              pend_nx = pend_nx | (NUM_IDS'(1) << set_id);
    pend_nx[0] = 1'b0;
    en_nx[0]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      en     <= '0;
      del_en <= 1'b0;
      thr    <= '0;
    end else begin
      pend <= pend_nx;
      en   <= en_nx;
      if (wr_del) del_en <= reg_wdata[0];
      if (wr_thr) thr    <= reg_wdata[ID_W-1:0];
    end
  end

  AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    win != '0 |-> (pend & en & (NUM_IDS'(1) << win)) != '0); // R4
  AST_WIN_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0 && int'(thr) <= NUM_IDS && win != '0) |-> win < thr); // R5
  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clm && win != '0 && !(set_valid && set_id == win))
      |=> (pend & (NUM_IDS'(1) << $past(win))) == '0); // R7
  AST_SET_BEATS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clm && set_valid && win != '0 && set_id == win)
      |=> (pend & (NUM_IDS'(1) << $past(set_id))) != '0); // R8
  AST_DEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_del |=> $stable(del_en)); // R9
endmodule

// File: tb/test_msi_intr_file.sv
module test_msi_intr_file;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_set;
    logic [2:0]  sel;
    logic [5:0]  idx;
    logic [31:0] data;
    logic [31:0] exp_top;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 6'd0, 32'd5,        32'h0,        1'b0, 8'd2},  // R2 pending, not enabled
    '{1'b0, 3'd4, 6'd0, 32'hFFFFFFFF, 32'h00050005, 1'b0, 8'd11}, // R11 no delivery yet
    '{1'b0, 3'd0, 6'd0, 32'hFFFFFFFF, 32'h00050005, 1'b1, 8'd11}, // R11 delivery on
    '{1'b1, 3'd0, 6'd0, 32'd3,        32'h00030003, 1'b1, 8'd4},  // R4 lower id wins
    '{1'b1, 3'd0, 6'd0, 32'd40,       32'h00030003, 1'b1, 8'd4},  // R4 disabled id
    '{1'b0, 3'd1, 6'd0, 32'd3,        32'h0,        1'b0, 8'd5},  // R5 strict below
    '{1'b0, 3'd1, 6'd0, 32'd4,        32'h00030003, 1'b1, 8'd5},  // R5
    '{1'b0, 3'd1, 6'd0, 32'd0,        32'h00030003, 1'b1, 8'd5},  // R5 zero = all
    '{1'b0, 3'd2, 6'd0, 32'h1234,     32'h00050005, 1'b1, 8'd7},  // R7 claim
    '{1'b0, 3'd1, 6'd0, 32'd100,      32'h00050005, 1'b1, 8'd5},  // R5 above count = all
    '{1'b0, 3'd4, 6'd1, 32'hFFFFFFFF, 32'h00050005, 1'b1, 8'd4},  // R4
    '{1'b0, 3'd3, 6'd0, 32'h0,        32'h00280028, 1'b1, 8'd6}   // R6 field encoding
  };

  logic        clk = 0, rst_n = 0, set_valid = 0, reg_wr = 0;
  logic [10:0] set_id = '0;
  logic [2:0]  reg_sel = '0;
  logic [5:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, top_val;
  logic        irq;
  int checks = 0, failures = 0;

  msi_intr_file i_msi_intr_file (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_id(set_id),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .top_val(top_val), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic setp(input logic [10:0] id);
    @(negedge clk); set_valid = 1; set_id = id;
    @(negedge clk); set_valid = 0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [5:0] idx, output logic [31:0] v);
    @(negedge clk); reg_sel = sel; reg_idx = idx; #1; v = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    check("R1 top", top_val, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int s = 0; s < 5; s++) begin
      rd(s[2:0], 6'd0, v);
      check("R1 reg", v, 0);
    end

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].is_set) setp(VECS[k].data[10:0]);
      else wr(VECS[k].sel, VECS[k].idx, VECS[k].data);
      check($sformatf("R%0d top step %0d", VECS[k].req, k), top_val, VECS[k].exp_top);
      check($sformatf("R%0d irq step %0d", VECS[k].req, k), {31'b0, irq}, {31'b0, VECS[k].exp_irq});
    end

    do_reset();
    wr(3'd3, 6'd0, 32'hFFFFFFFF);
    rd(3'd3, 6'd0, v); check("R3 pend word0", v, 32'hFFFFFFFE);
    wr(3'd4, 6'd0, 32'hFFFFFFFF);
    rd(3'd4, 6'd0, v); check("R3 en word0", v, 32'hFFFFFFFE);
    check("R4 lowest id", top_val, 32'h00010001);
    check("R11 no delivery", {31'b0, irq}, 0);
    wr(3'd0, 6'd0, 32'hFFFFFFFE);
    rd(3'd0, 6'd0, v); check("R9 bit0 only", v, 0);
    wr(3'd0, 6'd0, 32'h3);
    rd(3'd0, 6'd0, v); check("R9 readback", v, 1);
    check("R11 irq on", {31'b0, irq}, 1);
    wr(3'd1, 6'd0, 32'hFFFFFFFF);
    rd(3'd1, 6'd0, v); check("R10 thr mask", v, 32'h7FF);
    check("R5 large thr", top_val, 32'h00010001);
    rd(3'd2, 6'd0, v); check("R6 claim read", v, 32'h00010001);

    @(negedge clk); reg_wr = 1; reg_sel = 3'd2; reg_wdata = 0; set_valid = 1; set_id = 11'd1;
    @(negedge clk); reg_wr = 0; set_valid = 0;
    check("R8 set wins", top_val, 32'h00010001);
    wr(3'd2, 6'd0, 32'hDEAD);
    check("R7 claim clears", top_val, 32'h00020002);

    wr(3'd3, 6'd0, 32'h0);
    check("R6 none", top_val, 0);
    check("R11 irq off", {31'b0, irq}, 0);
    wr(3'd2, 6'd0, 32'hFFFFFFFF);
    rd(3'd3, 6'd0, v); check("R7 no winner", v, 0);

    setp(11'd0);
    rd(3'd3, 6'd0, v); check("R2 id0 ignored", v, 0);
    setp(11'd64);
    rd(3'd3, 6'd1, v); check("R2 out of range", v, 0);
    setp(11'd63);
    rd(3'd3, 6'd1, v); check("R2 id63", v, 32'h80000000);
    check("R4 disabled word1", top_val, 0);
    wr(3'd4, 6'd1, 32'h80000000);
    check("R6 id63", top_val, 32'h003F003F);
    wr(3'd3, 6'd5, 32'hFFFFFFFF);
    rd(3'd3, 6'd5, v); check("R12 bad idx", v, 0);
    check("R12 bad idx no effect", top_val, 32'h003F003F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule